// File: doc/BRIEF.md
# Multi-Mode Bus DMA Engine

This block is a single-channel copy engine. It moves a block of bytes from a byte-wide peripheral port into a 32-bit memory that it shares with a CPU. Software loads a destination address, a byte count and a bus-sharing policy, and then pulses a start input. The engine collects the incoming bytes into little-endian words. It writes each full word to memory in one bus cycle. A final partial word is written with only its valid byte strobes set.

An arbiter inside the block decides, cycle by cycle, whether the engine or the CPU owns the memory bus. The policy is chosen at start time:
- In burst mode the engine keeps the bus for the whole job.
- In cycle-stealing mode the engine never owns two cycles in a row.
- In transparent mode the engine takes only cycles the CPU does not ask for.

A CPU request that meets an engine-owned cycle is stalled with a wait indication and is never dropped. When the job ends, a sticky done flag is set and a one-cycle interrupt pulse is produced. A byte counter can be read at any time.

Top module: `bus_dma_engine`

## Requirements
- R1: After reset the block is idle: `sts_done`, `irq`, `per_ready`, `mem_we` and `bus_dma_own` are low, and `sts_remain` is 0.
- R2: Byte k of a job (counting from 0) is written in lane k mod 4 of the word at the start address plus 4·(k div 4). Lane i occupies `mem_wdata[8i+7:8i]` and strobe `mem_be[i]`. Every four bytes produce exactly one memory write.
- R3: For a final word holding n < 4 bytes, `mem_be` has only bits 0..n-1 set. The memory bytes in the other lanes keep their previous contents.
- R4: Bits [1:0] of `cfg_addr` are ignored, so the first write goes to the aligned word. `mem_addr` advances by 4 after each write.
- R5: Mode 2'b00 (burst), and the reserved code 2'b11, which behaves the same way, give the engine the bus from start until completion in one unbroken ownership period. This holds even when the peripheral pauses.
- R6: On every cycle with `cpu_req` high, exactly one of `cpu_gnt` and `cpu_wait` is high. `cpu_wait` is high exactly when the engine owns that cycle. A request that is held high is granted once the bus is free.
- R7: In mode 2'b01 (cycle-stealing), the engine never owns the bus on two consecutive cycles.
- R8: In mode 2'b10 (transparent), the engine never owns the bus on a cycle where `cpu_req` is high. While the CPU requests continuously, no memory write happens. The job completes once the CPU stops requesting.
- R9: In cycle-stealing and transparent modes, the engine owns the bus only on cycles where it performs a memory write.
- R10: Completion raises `irq` for exactly one cycle per job and sets `sts_done`. `sts_done` stays set until the next accepted start, which clears it on the following cycle.
- R11: `sts_remain` equals the programmed count minus the number of bytes already accepted from the peripheral.
- R12: A start pulse while a job is running is ignored. It changes neither the count, the address nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse, accepted only when idle |
| cfg_mode | input | 2 | Bus-sharing policy: 00 burst, 01 cycle-stealing, 10 transparent, 11 burst |
| cfg_addr | input | AW | Destination byte address (low two bits ignored) |
| cfg_len | input | LW | Byte count |
| sts_done | output | 1 | Sticky completion flag |
| sts_remain | output | LW | Bytes not yet taken from the peripheral |
| irq | output | 1 | One-cycle completion pulse |
| per_data | input | 8 | Peripheral byte |
| per_valid | input | 1 | Peripheral byte available |
| per_ready | output | 1 | Engine accepts the byte this cycle |
| cpu_req | input | 1 | CPU wants the memory bus this cycle |
| cpu_gnt | output | 1 | CPU owns the bus this cycle |
| cpu_wait | output | 1 | CPU access stalled this cycle |
| bus_dma_own | output | 1 | Engine owns the bus this cycle |
| mem_we | output | 1 | Memory word write |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Byte strobes for the write |

## Verification
The hardest case to reach is a word becoming ready on the cycle right after the engine has just written one. Only in that case can the cycle-stealing gap be seen at all. The stimulus reaches it with a 5-byte job and a peripheral that never pauses. The fifth byte arrives while the first word is being written, so the partial final word is ready one cycle later and must wait one more cycle. A second hard case is the transparent stall with a full word and a held partial word both pending. It is reached by keeping `cpu_req` high for the whole run and then releasing it.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        MODE_BURST = 2'b00,
        MODE_STEAL = 2'b01,
        MODE_GAP   = 2'b10,
        MODE_RSVD  = 2'b11
    } dma_mode_e;

endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dma_mode_e mode,
    input  logic      dma_req,
    input  logic      cpu_req,
    output logic      dma_gnt,
    output logic      cpu_gnt,
    output logic      cpu_wait
);

    typedef struct packed {
        logic prev_own;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d = arb_q;
        case (mode)
            MODE_STEAL: dma_gnt = dma_req && !arb_q.prev_own;
            MODE_GAP:   dma_gnt = dma_req && !cpu_req;
            default:    dma_gnt = dma_req;
        endcase
        cpu_gnt        = cpu_req && !dma_gnt;
        cpu_wait       = cpu_req && dma_gnt;
        arb_d.prev_own = dma_gnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

endmodule

// File: rtl/dma_packer.sv
module dma_packer #(
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                take,
    input  logic                last,
    input  logic [7:0]          byte_in,
    input  logic                pop,
    output logic                in_ready,
    output logic                out_valid,
    output logic [DW-1:0]       out_data,
    output logic [DW/8-1:0]     out_be,
    output logic                empty
);

    localparam int LANES = DW / 8;
    localparam int CW    = $clog2(LANES + 1);

    typedef struct packed {
        logic [DW-1:0]    acc;
        logic [CW-1:0]    cnt;
        logic             hold;
        logic [DW-1:0]    wd;
        logic [LANES-1:0] wbe;
        logic             wv;
    } pk_t;

    pk_t pk_d, pk_q;

    function automatic logic [LANES-1:0] lane_mask(input logic [CW-1:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (n > CW'(i));
        return m;
    endfunction

    logic [DW-1:0] acc_n;
    logic [CW-1:0] cnt_n;
    logic          complete;
    logic          free;

    always_comb begin
        pk_d  = pk_q;
        acc_n = pk_q.acc;
        cnt_n = pk_q.cnt;
        free  = !pk_q.wv || pop;
        if (pop) pk_d.wv = 1'b0;
        if (take) begin
            for (int i = 0; i < LANES; i++) begin
                if (pk_q.cnt == CW'(i)) acc_n[i*8 +: 8] = byte_in;
            end
            cnt_n = pk_q.cnt + 1'b1;
        end
        complete = pk_q.hold || (take && (cnt_n == CW'(LANES) || last));
        if (complete && free) begin
            pk_d.wd   = acc_n;
            pk_d.wbe  = lane_mask(cnt_n);
            pk_d.wv   = 1'b1;
            pk_d.acc  = '0;
            pk_d.cnt  = '0;
            pk_d.hold = 1'b0;
        end else begin
            pk_d.acc  = acc_n;
            pk_d.cnt  = cnt_n;
            pk_d.hold = complete;
        end
        if (clr) pk_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign in_ready  = !pk_q.hold;
    assign out_valid = pk_q.wv;
    assign out_data  = pk_q.wd;
    assign out_be    = pk_q.wbe;
    assign empty     = (pk_q.cnt == '0) && !pk_q.hold && !pk_q.wv;

endmodule

// File: rtl/bus_dma_engine.sv
module bus_dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_start,
    input  logic [1:0]      cfg_mode,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [LW-1:0]   cfg_len,
    output logic            sts_done,
    output logic [LW-1:0]   sts_remain,
    output logic            irq,
    input  logic [7:0]      per_data,
    input  logic            per_valid,
    output logic            per_ready,
    input  logic            cpu_req,
    output logic            cpu_gnt,
    output logic            cpu_wait,
    output logic            bus_dma_own,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be
);

    localparam int          LANES = DW / 8;
    localparam logic [AW-1:0] STEP = AW'(LANES);
    localparam logic [AW-1:0] ALIGN_MASK = ~(STEP - 1'b1);

    typedef struct packed {
        logic          run;
        dma_mode_e     mode;
        logic [AW-1:0] addr;
        logic [LW-1:0] remain;
        logic          done;
        logic          irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             take, accept, dma_req, dma_gnt;
    logic             pk_ready, pk_valid, pk_empty;
    logic [DW-1:0]    pk_data;
    logic [LANES-1:0] pk_be;
    dma_mode_e        mode_cur;
    logic             run_cur;

    assign accept    = !ctl_q.run && cfg_start;
    assign per_ready = ctl_q.run && (ctl_q.remain != '0) && pk_ready;
    assign take      = per_valid && per_ready;
    assign dma_req   = ctl_q.run && (ctl_q.mode == MODE_BURST || pk_valid);
    assign mem_we    = dma_gnt && pk_valid;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        if (take)   ctl_d.remain = ctl_q.remain - 1'b1;
        if (mem_we) ctl_d.addr   = ctl_q.addr + STEP;
        if (ctl_q.run && ctl_q.remain == '0 && pk_empty) begin
            ctl_d.run  = 1'b0;
            ctl_d.done = 1'b1;
            ctl_d.irq  = 1'b1;
        end
        if (accept) begin
            ctl_d.run    = 1'b1;
            ctl_d.done   = 1'b0;
            ctl_d.mode   = (cfg_mode == MODE_RSVD) ? MODE_BURST : dma_mode_e'(cfg_mode);
            ctl_d.addr   = cfg_addr & ALIGN_MASK;
            ctl_d.remain = cfg_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b0, mode: MODE_BURST, addr: '0,
                               remain: '0, done: 1'b0, irq: 1'b0};
        else        ctl_q <= ctl_d;
    end

    dma_packer #(.DW(DW)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .take      (take),
        .last      (ctl_q.remain == LW'(1)),
        .byte_in   (per_data),
        .pop       (mem_we),
        .in_ready  (pk_ready),
        .out_valid (pk_valid),
        .out_data  (pk_data),
        .out_be    (pk_be),
        .empty     (pk_empty)
    );

    dma_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (ctl_q.mode),
        .dma_req  (dma_req),
        .cpu_req  (cpu_req),
        .dma_gnt  (dma_gnt),
        .cpu_gnt  (cpu_gnt),
        .cpu_wait (cpu_wait)
    );

    assign mode_cur    = ctl_q.mode;
    assign run_cur     = ctl_q.run;
    assign bus_dma_own = dma_gnt;
    assign sts_done    = ctl_q.done;
    assign sts_remain  = ctl_q.remain;
    assign irq         = ctl_q.irq;
    assign mem_addr    = ctl_q.addr;
    assign mem_wdata   = pk_data;
    assign mem_be      = pk_be;

endmodule

// File: rtl/bus_dma_engine_chk.sv
module bus_dma_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          run,
    input logic          cpu_req,
    input logic          cpu_gnt,
    input logic          cpu_wait,
    input logic          own,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          irq,
    input logic          done,
    input logic          per_ready
);

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && run && own) |=> (own || !run));

    // R5
    burst_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && run) |-> own);

    // R6
    cpu_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_gnt != cpu_wait));

    // R6
    cpu_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && own) |-> cpu_wait);

    // R7
    steal_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && own) |=> !own);

    // R8
    gap_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && cpu_req) |-> !own);

    // R9
    own_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && own) |-> mem_we);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == $past(mem_addr) + AW'(4)));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    // R1
    ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ready |-> run);

endmodule

bind bus_dma_engine bus_dma_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_cur),
    .run       (run_cur),
    .cpu_req   (cpu_req),
    .cpu_gnt   (cpu_gnt),
    .cpu_wait  (cpu_wait),
    .own       (bus_dma_own),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .done      (sts_done),
    .per_ready (per_ready)
);

// File: tb/bus_dma_engine_tb.sv
module bus_dma_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [31:0] cfg_addr = '0;
    logic [15:0] cfg_len = '0;
    logic        sts_done, irq, per_ready, cpu_gnt, cpu_wait, bus_dma_own, mem_we;
    logic [15:0] sts_remain;
    logic [7:0]  per_data = '0;
    logic        per_valid = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;

    always #5 clk = ~clk;

    bus_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len), .sts_done(sts_done),
        .sts_remain(sts_remain), .irq(irq), .per_data(per_data),
        .per_valid(per_valid), .per_ready(per_ready), .cpu_req(cpu_req),
        .cpu_gnt(cpu_gnt), .cpu_wait(cpu_wait), .bus_dma_own(bus_dma_own),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
    );

    int errs = 0;
    int checks = 0;
    logic [31:0] mem [64];
    logic [31:0] expm [64];

    bit       p_en = 1'b0;
    bit       p_gap = 1'b0;
    int       p_idx = 0;
    int       p_limit = 0;
    logic [7:0] p_base = '0;
    bit       cpu_on = 1'b0;

    int own_rise = 0, consec = 0, irq_cnt = 0, irq_long = 0;
    int lost = 0, wr_cnt = 0, wait_cnt = 0, cyc = 0;
    logic own_prev = 1'b0, irq_prev = 1'b0;

    // stimulus at the falling edge, sampling 3 ns later (before the rising edge)
    always begin
        @(negedge clk);
        cyc++;
        per_valid = p_en && (p_idx < p_limit) && !(p_gap && (cyc % 3 == 0));
        per_data  = p_base + 8'(p_idx * 7);
        cpu_req   = cpu_on;
        #3;
        if (rst_n) begin
            if (per_valid && per_ready) p_idx++;
            if (mem_we) begin
                wr_cnt++;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end
            if (bus_dma_own && !own_prev) own_rise++;
            if (bus_dma_own && own_prev) consec++;
            own_prev = bus_dma_own;
            if (irq) irq_cnt++;
            if (irq && irq_prev) irq_long++;
            irq_prev = irq;
            if (cpu_req && !cpu_gnt && !cpu_wait) lost++;
            if (cpu_wait) wait_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        own_rise = 0; consec = 0; irq_cnt = 0; irq_long = 0;
        lost = 0; wr_cnt = 0; wait_cnt = 0; p_idx = 0; p_gap = 1'b0;
        for (int i = 0; i < 64; i++) begin
            mem[i]  = 32'hAAAA_AAAA;
            expm[i] = 32'hAAAA_AAAA;
        end
    endtask

    task automatic build_exp(input int addr, input int len, input logic [7:0] base);
        for (int k = 0; k < len; k++)
            expm[((addr >> 2) + k / 4) % 64][(k % 4) * 8 +: 8] = base + 8'(k * 7);
    endtask

    task automatic go(input logic [1:0] m, input logic [31:0] a, input logic [15:0] n);
        @(negedge clk);
        cfg_mode = m; cfg_addr = a; cfg_len = n; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (sts_done) begin seen = 1'b1; break; end
        end
        chk(req, "job completes", seen, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_mem(input string req);
        int mism = 0;
        for (int i = 0; i < 64; i++) if (mem[i] !== expm[i]) mism++;
        chk(req, "memory words mismatching", mism, 0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "done after reset", sts_done, 0);
        chk("R1", "irq after reset", irq, 0);
        chk("R1", "per_ready after reset", per_ready, 0);
        chk("R1", "mem_we after reset", mem_we, 0);
        chk("R1", "own after reset", bus_dma_own, 0);
        chk("R1", "remain after reset", sts_remain, 0);
    endtask

    task automatic t_burst();
        clear_stats();
        p_base = 8'h10; p_limit = 8; p_en = 1'b1; cpu_on = 1'b1;
        build_exp(32'h40, 8, 8'h10);
        go(2'b00, 32'h40, 16'd8);
        wait_done("R10");
        cmp_mem("R2");
        chk("R2", "write count", wr_cnt, 2);
        chk("R5", "ownership periods", own_rise, 1);
        chk("R6", "cpu saw wait states", wait_cnt > 0, 1);
        chk("R6", "cpu request lost", lost, 0);
        chk("R6", "cpu granted after job", cpu_gnt, 1);
        chk("R10", "irq pulses", irq_cnt, 1);
        chk("R10", "irq longer than one cycle", irq_long, 0);
        chk("R10", "done sticky", sts_done, 1);
        cpu_on = 1'b0;
    endtask

    task automatic t_steal();
        clear_stats();
        p_base = 8'h31; p_limit = 5; cpu_on = 1'b0;
        build_exp(32'h80, 5, 8'h31);
        go(2'b01, 32'h80, 16'd5);
        wait_done("R7");
        cmp_mem("R3");
        chk("R3", "partial word upper lanes", mem[33][31:8], 24'hAAAAAA);
        chk("R7", "consecutive owned cycles", consec, 0);
        chk("R9", "ownership periods equal writes", own_rise, 2);
        chk("R4", "write count", wr_cnt, 2);
    endtask

    task automatic t_gap();
        clear_stats();
        p_base = 8'h55; p_limit = 6; cpu_on = 1'b1;
        build_exp(32'h20, 6, 8'h55);
        go(2'b10, 32'h20, 16'd6);
        repeat (40) @(negedge clk);
        chk("R8", "writes while cpu busy", wr_cnt, 0);
        chk("R8", "engine owned cycles while cpu busy", own_rise, 0);
        chk("R11", "remain after all bytes taken", sts_remain, 0);
        chk("R8", "not done while cpu busy", sts_done, 0);
        chk("R6", "cpu request lost", lost, 0);
        cpu_on = 1'b0;
        wait_done("R8");
        cmp_mem("R8");
        chk("R8", "write count after release", wr_cnt, 2);
    endtask

    task automatic t_rsvd();
        clear_stats();
        p_base = 8'h02; p_limit = 4; p_gap = 1'b1; cpu_on = 1'b1;
        build_exp(32'h60, 4, 8'h02);
        go(2'b11, 32'h61, 16'd4);
        wait_done("R5");
        cmp_mem("R4");
        chk("R5", "reserved mode single ownership period", own_rise, 1);
        chk("R5", "reserved mode stalls cpu", wait_cnt > 0, 1);
        cpu_on = 1'b0;
    endtask

    task automatic t_remain();
        clear_stats();
        p_base = 8'h70; p_limit = 3; cpu_on = 1'b0;
        build_exp(32'h10, 7, 8'h70);
        go(2'b10, 32'h10, 16'd7);
        repeat (10) @(negedge clk);
        chk("R11", "remain after three bytes", sts_remain, 4);
        chk("R11", "no write before a full word", wr_cnt, 0);
        go(2'b00, 32'h30, 16'd2);
        repeat (3) @(negedge clk);
        chk("R12", "remain unchanged by busy start", sts_remain, 4);
        chk("R12", "not done after busy start", sts_done, 0);
        p_limit = 7;
        wait_done("R12");
        cmp_mem("R12");
        chk("R12", "write count", wr_cnt, 2);
        chk("R10", "irq pulses", irq_cnt, 1);
    endtask

    task automatic t_restart();
        clear_stats();
        p_base = 8'hC3; p_limit = 1; cpu_on = 1'b0;
        build_exp(32'h00, 1, 8'hC3);
        chk("R10", "done still set before restart", sts_done, 1);
        go(2'b01, 32'h00, 16'd1);
        chk("R10", "done cleared by start", sts_done, 0);
        wait_done("R10");
        cmp_mem("R3");
        chk("R3", "single byte upper lanes", mem[0][31:8], 24'hAAAAAA);
    endtask

    initial begin
        #1_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_burst();
        t_steal();
        t_gap();
        t_rsvd();
        t_remain();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule